// File: doc/BRIEF.md
# Byte-Wide Memory with BCD Calendar Clock

This block is a byte-wide static memory whose highest eight byte locations hold a calendar clock. The other locations are plain storage. A hidden set of BCD counters keeps the time and advances on every pulse of a one-per-second tick input. Each tick also copies the new counter values into seven host-visible clock bytes. The host reads and writes the clock bytes over the same bus as any other byte. The eighth location is a control byte. It holds two freeze bits and a six-bit calibration field that is kept only as stored data.

The host bus uses active-low chip enable, output enable and write enable, an address and separate input and output data buses. An output-enable flag stands in for the tristate drivers. A power-fail input blocks every write while the counters keep running. The address width is a parameter: 15 gives the full 32K x 8 array, and the default is a smaller array with the same layout.

Top module: `bcd_rtc_sram`

## Requirements
- R1: At an address below the clock region, a byte written on one clock edge reads back unchanged on later reads.
- R2: `dout_en` is 1 only when `ce_n`=0, `we_n`=1 and `oe_n`=0. In every other bus state it is 0.
- R3: A write takes place on a clock edge where `ce_n`=0 and `we_n`=0, whatever the level of `oe_n`. No output is driven during a write.
- R4: After reset, the clock bytes read as seconds 00, minutes 00, hours 00, weekday 01, date 01, month 01 and year 00, and the control byte reads 00.
- R5: Each tick advances seconds from 00 to 59, minutes from 00 to 59 and hours from 00 to 23, all in BCD. A carry passes to the next field when a field wraps.
- R6: The weekday counts 1 to 7. The date wraps to 01 after the last day of the month: 31 days, 30 for months 04, 06, 09 and 11, and 28 for month 02, or 29 when the year is divisible by four.
- R7: The month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00.
- R8: The clock bytes sit at offsets 1 to 7 above base (2^ADDR_W - 8): seconds, minutes, hours, weekday, date, month, year. They are reloaded from the counters on each tick. A host write to one of them holds until the next tick and does not change the counters.
- R9: While control bit 6 (read freeze) is 1, ticks leave the clock bytes unchanged and the counters keep advancing.
- R10: While control bit 7 (write freeze) is 1, ticks leave the clock bytes unchanged. A control write that changes bit 7 from 1 to 0 loads all seven clock bytes into the counters.
- R11: Control byte bits 5 to 0 are stored as written and read back unchanged. The control byte is at offset 0 of the clock region.
- R12: While `pwr_fail` is 1, no write changes the memory, the control byte or a clock byte, and ticks still advance the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data (valid when dout_en is 1) |
| dout_en | output | 1 | Output-drive flag for the data bus |
| sec_tick | input | 1 | One-cycle pulse once per second |
| pwr_fail | input | 1 | Power-fail flag that blocks writes |

## Verification
The bench loads 23:59:59 on the last day of every month for years 00, 01, 04, 96 and 99, then checks every field after one tick. A wrong month-length table or a wrong leap rule lands on a wrong date, and a broken carry chain leaves the month or year stuck or wraps it wrongly. It also checks both freeze bits. If refresh is not blocked, the snapshot advances. If the load on clearing the write bit is missing, the counters keep their old time. A missing power-fail gate shows up as overwritten memory and control bytes. A full sweep of the plain memory, with `oe_n` toggled during writes, catches address decode that spills into or out of the clock region.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   typedef struct packed {
      logic [7:0] year;
      logic [7:0] month;
      logic [7:0] date;
      logic [7:0] dow;
      logic [7:0] hour;
      logic [7:0] min;
      logic [7:0] sec;
   } rtc_time_t;

   localparam int NUM_FIELDS = 7;
   localparam logic [2:0] OFS_CTRL = 3'd0;
   localparam int FREEZE_WR_BIT = 7;
   localparam int FREEZE_RD_BIT = 6;

   localparam rtc_time_t RST_TIME = '{year: 8'h00, month: 8'h01, date: 8'h01,
                                      dow: 8'h01, hour: 8'h00, min: 8'h00, sec: 8'h00};

   // Returns {wrapped, next} for a BCD field counting lo..hi
   function automatic logic [8:0] bcd_wrap_inc(input logic [7:0] v,
                                               input logic [7:0] lo,
                                               input logic [7:0] hi);
      if (v >= hi)              return {1'b1, lo};
      else if (v[3:0] >= 4'd9)  return {1'b0, v[7:4] + 4'd1, 4'd0};
      else                      return {1'b0, v + 8'd1};
   endfunction

   // BCD year divisible by four: tens even and ones in {0,4,8}, or tens odd and ones in {2,6}
   function automatic logic is_leap(input logic [7:0] yr);
      if (!yr[4]) return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
      else        return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
   endfunction

   function automatic logic [7:0] month_last_day(input logic [7:0] mo, input logic [7:0] yr);
      case (mo)
         8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction
endpackage

// File: rtl/rtc_sram_array.sv
module rtc_sram_array #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 2 ** ADDR_W;

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem_q[addr] <= wdata;
   end

   assign rdata = mem_q[addr];
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
   import rtc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  logic      load,
   input  rtc_time_t load_val,
   output rtc_time_t cnt,
   output rtc_time_t cnt_nxt
);
   rtc_time_t cnt_q;

   always_comb begin
      logic [8:0] s;
      logic       c;
      cnt_nxt = cnt_q;
      s = bcd_wrap_inc(cnt_q.sec, 8'h00, 8'h59);
      cnt_nxt.sec = s[7:0];
      c = s[8];
      s = bcd_wrap_inc(cnt_q.min, 8'h00, 8'h59);
      if (c) cnt_nxt.min = s[7:0];
      c = c & s[8];
      s = bcd_wrap_inc(cnt_q.hour, 8'h00, 8'h23);
      if (c) cnt_nxt.hour = s[7:0];
      c = c & s[8];
      s = bcd_wrap_inc(cnt_q.dow, 8'h01, 8'h07);
      if (c) cnt_nxt.dow = s[7:0];
      s = bcd_wrap_inc(cnt_q.date, 8'h01, month_last_day(cnt_q.month, cnt_q.year));
      if (c) cnt_nxt.date = s[7:0];
      c = c & s[8];
      s = bcd_wrap_inc(cnt_q.month, 8'h01, 8'h12);
      if (c) cnt_nxt.month = s[7:0];
      c = c & s[8];
      s = bcd_wrap_inc(cnt_q.year, 8'h00, 8'h99);
      if (c) cnt_nxt.year = s[7:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt_q <= RST_TIME;
      else if (load)  cnt_q <= load_val;
      else if (tick)  cnt_q <= cnt_nxt;
   end

   assign cnt = cnt_q;
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
   import rtc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [2:0] ofs,
   input  logic [7:0] wr_data,
   input  logic       tick,
   input  rtc_time_t  cnt_nxt,
   output logic [7:0] rd_data,
   output logic [7:0] ctrl,
   output rtc_time_t  shd,
   output logic       frozen,
   output logic       load
);
   localparam logic [8*NUM_FIELDS-1:0] RST_BITS = RST_TIME;

   logic [7:0]                ctrl_q;
   logic [7:0]                shd_q [NUM_FIELDS];
   logic [8*NUM_FIELDS-1:0]   nxt_bits;
   logic [8*NUM_FIELDS-1:0]   shd_bits;
   logic [7:0]                bytes8 [8];

   assign nxt_bits = cnt_nxt;
   assign frozen   = ctrl_q[FREEZE_WR_BIT] | ctrl_q[FREEZE_RD_BIT];
   assign load     = wr_en && (ofs == OFS_CTRL) && ctrl_q[FREEZE_WR_BIT] && !wr_data[FREEZE_WR_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n)                             ctrl_q <= 8'h00;
      else if (wr_en && (ofs == OFS_CTRL))    ctrl_q <= wr_data;
   end

   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
      always_ff @(posedge clk) begin
         if (!rst_n)                                shd_q[i] <= RST_BITS[i*8 +: 8];
         else if (wr_en && (ofs == 3'(i + 1)))      shd_q[i] <= wr_data;
         else if (tick && !frozen)                  shd_q[i] <= nxt_bits[i*8 +: 8];
      end
      assign shd_bits[i*8 +: 8] = shd_q[i];
      assign bytes8[i+1]        = shd_q[i];
   end

   assign bytes8[0] = ctrl_q;
   assign rd_data   = bytes8[ofs];
   assign ctrl      = ctrl_q;
   assign shd       = rtc_time_t'(shd_bits);
endmodule

// File: rtl/bcd_rtc_sram.sv
module bcd_rtc_sram
   import rtc_pkg::*;
#(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        din,
   output logic [7:0]        dout,
   output logic              dout_en,
   input  logic              sec_tick,
   input  logic              pwr_fail
);
   if (ADDR_W < 4 || ADDR_W > 15) begin : g_bad_addr_w
      $error("bcd_rtc_sram: ADDR_W must be 4..15");
   end

   logic       in_clk;
   logic       host_wr;
   logic       mem_we;
   logic       reg_we;
   logic [7:0] mem_rd;
   logic [7:0] reg_rd;
   logic [7:0] ctrl_w;
   logic       frozen_w;
   logic       load_w;
   rtc_time_t  cnt_w;
   rtc_time_t  nxt_w;
   rtc_time_t  shd_w;

   assign in_clk  = &addr[ADDR_W-1:3];
   assign host_wr = !ce_n && !we_n && !pwr_fail;
   assign mem_we  = host_wr && !in_clk;
   assign reg_we  = host_wr && in_clk;

   rtc_sram_array #(.ADDR_W(ADDR_W), .DATA_W(8)) i_mem (
      .clk(clk), .we(mem_we), .addr(addr), .wdata(din), .rdata(mem_rd)
   );

   rtc_counter i_cnt (
      .clk(clk), .rst_n(rst_n), .tick(sec_tick), .load(load_w),
      .load_val(shd_w), .cnt(cnt_w), .cnt_nxt(nxt_w)
   );

   rtc_regs i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .ofs(addr[2:0]), .wr_data(din),
      .tick(sec_tick), .cnt_nxt(nxt_w), .rd_data(reg_rd), .ctrl(ctrl_w),
      .shd(shd_w), .frozen(frozen_w), .load(load_w)
   );

   assign dout_en = !ce_n && we_n && !oe_n;
   assign dout    = in_clk ? reg_rd : mem_rd;
endmodule

// File: rtl/rtc_chk.sv
module rtc_chk
   import rtc_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       ce_n,
   input logic       we_n,
   input logic       dout_en,
   input logic       sec_tick,
   input logic       pwr_fail,
   input logic       reg_we,
   input logic       frozen,
   input logic       load,
   input logic [7:0] ctrl,
   input rtc_time_t  cnt,
   input rtc_time_t  shd
);
   // R2
   deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) ce_n |-> !dout_en);
   // R3
   write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n) !we_n |-> !dout_en);
   // R12
   pwr_ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) pwr_fail |=> $stable(ctrl));
   // R12
   pwr_shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_fail && !sec_tick) |=> $stable(shd));
   // R5
   tick_moves_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && !load) |=> (cnt.sec != $past(cnt.sec)));
   // R8
   refresh_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && !frozen && !reg_we) |=> (shd == cnt));
   // R9
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frozen && !reg_we) |=> $stable(shd));
   // R10
   load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == $past(shd)));
endmodule

bind bcd_rtc_sram rtc_chk i_chk (
   .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .dout_en(dout_en),
   .sec_tick(sec_tick), .pwr_fail(pwr_fail), .reg_we(reg_we), .frozen(frozen_w),
   .load(load_w), .ctrl(ctrl_w), .cnt(cnt_w), .shd(shd_w)
);

// File: tb/test_bcd_rtc_sram.sv
module test_bcd_rtc_sram;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 11;
   localparam int DEPTH = 2 ** AW;
   localparam int BASE = DEPTH - 8;

   logic clk = 0, rst_n = 0, ce_n = 1, oe_n = 1, we_n = 1, sec_tick = 0, pwr_fail = 0;
   logic [AW-1:0] addr = '0;
   logic [7:0] din = '0;
   logic [7:0] dout;
   logic dout_en;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit done = 0;
   int m_t [7];   // sec,min,hour,dow,date,month,year as integers

   bcd_rtc_sram #(.ADDR_W(AW)) i_bcd_rtc_sram (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
      .din(din), .dout(dout), .dout_en(dout_en), .sec_tick(sec_tick), .pwr_fail(pwr_fail)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc >= 150000 && !done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   function automatic logic [7:0] bcd(input int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction
   function automatic int mlen(input int mo, input int yr);
      if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction
   function automatic logic [7:0] pat(input int a);
      return 8'((a * 7 + 3) & 255);
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [7:0] d, input logic oe);
      @(negedge clk);
      addr = AW'(a); din = d; ce_n = 0; we_n = 0; oe_n = oe;
      @(negedge clk);
      ce_n = 1; we_n = 1; oe_n = 1;
   endtask

   task automatic rd(input int a, output logic [7:0] d);
      @(negedge clk);
      addr = AW'(a); ce_n = 0; we_n = 1; oe_n = 0;
      #1 d = dout;
      ce_n = 1; oe_n = 1;
   endtask

   task automatic tick();
      @(negedge clk); sec_tick = 1;
      @(negedge clk); sec_tick = 0;
   endtask

   task automatic model_tick();
      m_t[0]++;
      if (m_t[0] > 59) begin
         m_t[0] = 0; m_t[1]++;
         if (m_t[1] > 59) begin
            m_t[1] = 0; m_t[2]++;
            if (m_t[2] > 23) begin
               m_t[2] = 0;
               m_t[3] = (m_t[3] >= 7) ? 1 : m_t[3] + 1;
               m_t[4]++;
               if (m_t[4] > mlen(m_t[5], m_t[6])) begin
                  m_t[4] = 1; m_t[5]++;
                  if (m_t[5] > 12) begin
                     m_t[5] = 1;
                     m_t[6] = (m_t[6] + 1) % 100;
                  end
               end
            end
         end
      end
   endtask

   task automatic check_all(input string req);
      logic [7:0] v;
      for (int i = 0; i < 7; i++) begin
         rd(BASE + 1 + i, v);
         check(req, v, bcd(m_t[i]));
      end
   endtask

   task automatic set_time(input int s, input int mi, input int h, input int dw,
                           input int dt, input int mo, input int yr);
      wr(BASE, 8'h80, 1);
      m_t[0] = s; m_t[1] = mi; m_t[2] = h; m_t[3] = dw; m_t[4] = dt; m_t[5] = mo; m_t[6] = yr;
      for (int i = 0; i < 7; i++) wr(BASE + 1 + i, bcd(m_t[i]), 1);
      wr(BASE, 8'h00, 1);   // R10 load on clearing write bit
   endtask

   initial begin
      logic [7:0] v, held;
      int yrs [5] = '{0, 1, 4, 96, 99};
      m_t = '{0, 0, 0, 1, 1, 1, 0};
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R4 reset state
      rd(BASE, v); check("R4 ctrl", v, 8'h00);
      check_all("R4 reset time");

      // R2 bus output enable
      @(negedge clk); ce_n = 1; we_n = 1; oe_n = 0; #1 check("R2 deselect", 8'(dout_en), 8'h00);
      @(negedge clk); ce_n = 0; we_n = 1; oe_n = 1; #1 check("R2 oe high", 8'(dout_en), 8'h00);
      @(negedge clk); ce_n = 0; we_n = 1; oe_n = 0; #1 check("R2 read", 8'(dout_en), 8'h01);
      @(negedge clk); ce_n = 0; we_n = 0; oe_n = 0; addr = '0; din = pat(0);
      #1 check("R3 write no drive", 8'(dout_en), 8'h00);
      @(negedge clk); ce_n = 1; we_n = 1; oe_n = 1;

      // R1/R3 memory sweep, oe_n toggled during writes
      for (int a = 0; a < BASE; a++) wr(a, pat(a), 1'(a & 1));
      for (int a = 0; a < BASE; a++) begin
         rd(a, v); check("R1 R3 mem", v, pat(a));
      end

      // R5 second/minute counting
      for (int k = 0; k < 130; k++) begin
         tick(); model_tick();
         rd(BASE + 1, v); check("R5 sec", v, bcd(m_t[0]));
         rd(BASE + 2, v); check("R5 min", v, bcd(m_t[1]));
      end

      // R6/R7 month ends across leap and century-end years
      for (int mo = 1; mo <= 12; mo++) begin
         foreach (yrs[j]) begin
            set_time(59, 59, 23, 7, mlen(mo, yrs[j]), mo, yrs[j]);
            rd(BASE, v); check("R10 R11 ctrl after load", v, 8'h00);
            tick(); model_tick();
            check_all("R6 R7 rollover");
         end
      end
      set_time(59, 59, 23, 3, 28, 2, 4);
      tick(); model_tick(); check_all("R6 leap feb 28");

      // R8 host write to clock byte holds until tick
      wr(BASE + 1, 8'h33, 1);
      rd(BASE + 1, v); check("R8 host write holds", v, 8'h33);
      tick(); model_tick(); check_all("R8 refresh");

      // R9 read freeze
      wr(BASE, 8'h40, 1);
      rd(BASE + 1, held);
      repeat (3) begin tick(); model_tick(); end
      rd(BASE + 1, v); check("R9 frozen snapshot", v, held);
      wr(BASE, 8'h00, 1);
      tick(); model_tick(); check_all("R9 counters kept running");

      // R10 write freeze and load
      wr(BASE, 8'h80, 1);
      wr(BASE + 1, 8'h10, 1);
      tick();
      rd(BASE + 1, v); check("R10 no refresh", v, 8'h10);
      m_t[0] = 10;
      wr(BASE, 8'h00, 1);
      tick(); model_tick(); check_all("R10 loaded");

      // R11 calibration storage
      wr(BASE, 8'h15, 1); rd(BASE, v); check("R11 calib", v, 8'h15);
      wr(BASE, 8'h2A, 0); rd(BASE, v); check("R11 calib", v, 8'h2A);
      wr(BASE, 8'h00, 1);

      // R12 power fail
      pwr_fail = 1;
      wr(5, ~pat(5), 1);
      wr(BASE, 8'h40, 1);
      wr(BASE + 1, 8'h44, 1);
      rd(5, v); check("R12 mem", v, pat(5));
      rd(BASE, v); check("R12 ctrl", v, 8'h00);
      tick(); model_tick();
      rd(BASE + 1, v); check("R12 sec", v, bcd(m_t[0]));
      pwr_fail = 0;
      tick(); model_tick(); check_all("R12 counters ran");

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule